// File: doc/BRIEF.md
# Port-Configured GPIO Controller

This block holds the control state for a bank of general-purpose pins grouped into 8-bit ports, three ports by default. Each port has an output data latch, a per-pin interrupt enable mask and one 2-bit mode field that applies to every pin of the port. From a pin's data bit and its port's mode, the block derives three pad controls: a pull-up enable, a low-side sink enable and a high-side drive enable. The pad itself lies outside the block. It is represented by those three enables and one sampled input bit per pin.

Software writes and reads the block over a simple register interface. A read of a port's data location returns the pad levels after a two-flop synchronizer, not the contents of the latch. This lets an open-drain or pulled-up pin also serve as an input. Each synchronized input that rises produces a one-cycle interrupt request toward an interrupt controller, provided that pin's interrupt enable is set.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every data latch holds all ones, every port is in resistive mode and every interrupt enable is 0. As a result `pu_en` is all ones, `sink_en`, `drive_en` and `irq_req` are all zero, and mode and enable reads return 0.
- R2: The register address is {port index, kind}, with kind in the two low bits: 00 data latch, 01 mode, 10 interrupt enable, 11 unused. A write updates the addressed register at the next rising clock edge.
- R3: A pin's `pu_en` is 1 only when its port's mode is 00 (resistive) and the pin's data bit is 1.
- R4: A pin's `sink_en` equals the inverse of its data bit in every mode.
- R5: A pin's `drive_en` is 1 only when its port's mode is 01 (push-pull) and the pin's data bit is 1.
- R6: Mode 10 (open-drain) and mode 11 (reserved) behave identically. With data 1, all three enables are off and the pin is a high-impedance input.
- R7: One mode field controls all eight pins of a port. Writing one port's mode or data leaves the other ports' pad controls unchanged.
- R8: A read of kind 00 returns the pad input levels delayed by two clock edges, independent of the data latch.
- R9: A read of kind 01 returns the port's mode in bits 1:0 with zeros above. Kind 10 returns the enable mask. Kind 11 or a port index with no port returns 0.
- R10: `irq_req` for a pin pulses high for exactly one cycle when the pin's synchronized level rises and its interrupt enable is 1. A falling level, or a rising level with the enable at 0, raises no request.
- R11: A write to kind 11 or to a port index with no port changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address {port, kind} |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address {port, kind} |
| rd_data | output | 8 | Read data (combinational from rd_addr) |
| pad_in | input | 24 | Sampled pad input levels, port p at bits 8p+7:8p |
| pu_en | output | 24 | Pull-up enable per pin |
| sink_en | output | 24 | Low-side sink enable per pin |
| drive_en | output | 24 | High-side drive enable per pin |
| irq_req | output | 24 | Per-pin interrupt request pulse |

## Verification
A corrupted data latch or mode field shows up on the pad enables in the same cycle, because the enables decode the registered state directly. The bench therefore checks `pu_en`, `sink_en` and `drive_en` one cycle after each write. A fault in the synchronizer chain appears as a read value one edge early or late, or as an interrupt pulse that arrives in the wrong cycle or lasts more than one cycle. Both are sampled at exact cycle offsets from the pad change. A write that lands on the wrong port is caught through the untouched ports' enables and readback.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    typedef enum logic [1:0] {
        PM_RESIST   = 2'b00,
        PM_PUSHPULL = 2'b01,
        PM_OPEN     = 2'b10,
        PM_OPEN_RSV = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        RK_DATA  = 2'b00,
        RK_MODE  = 2'b01,
        RK_IRQEN = 2'b10,
        RK_NONE  = 2'b11
    } reg_kind_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_ctrl_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [1:0]        wr_kind,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] data_o,
    output logic [1:0]        mode_o,
    output logic [PORT_W-1:0] ie_o
);

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [1:0]        mode;
        logic [PORT_W-1:0] ie;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            case (wr_kind)
                RK_DATA:  st_d.data = wr_data;
                RK_MODE:  st_d.mode = wr_data[1:0];
                RK_IRQEN: st_d.ie   = wr_data;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '1;
            st_q.mode <= PM_RESIST;
            st_q.ie   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign mode_o = st_q.mode;
    assign ie_o   = st_q.ie;

    // R2
    data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_kind == RK_DATA) |=> (data_o == $past(wr_data)));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && wr_kind == RK_MODE) |=> $stable(mode_o));

    // R11
    none_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_kind == RK_NONE) |=> ($stable(data_o) && $stable(ie_o)));

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
    import gpio_ctrl_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [1:0]        mode_i,
    input  logic [PORT_W-1:0] data_i,
    output logic [PORT_W-1:0] pu_o,
    output logic [PORT_W-1:0] sink_o,
    output logic [PORT_W-1:0] drive_o
);

    logic is_resist;
    logic is_pushpull;

    always_comb begin
        is_resist   = (mode_i == PM_RESIST);
        is_pushpull = (mode_i == PM_PUSHPULL);
        for (int i = 0; i < PORT_W; i++) begin
            pu_o[i]    = is_resist   &  data_i[i];
            drive_o[i] = is_pushpull &  data_i[i];
            sink_o[i]  = ~data_i[i];
        end
    end

endmodule

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pad_i,
    input  logic [PORT_W-1:0] ie_i,
    output logic [PORT_W-1:0] level_o,
    output logic [PORT_W-1:0] irq_o
);

    typedef struct packed {
        logic [PORT_W-1:0] s1;
        logic [PORT_W-1:0] s2;
        logic [PORT_W-1:0] prev;
    } sync_state_t;

    sync_state_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pad_i;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign level_o = sy_q.s2;
    assign irq_o   = sy_q.s2 & ~sy_q.prev & ie_i;

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & $past(irq_o)) == '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~ie_i) == '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = PSEL_W + 2,
    localparam int PIN_N    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PIN_N-1:0]  pad_in,
    output logic [PIN_N-1:0]  pu_en,
    output logic [PIN_N-1:0]  sink_en,
    output logic [PIN_N-1:0]  drive_en,
    output logic [PIN_N-1:0]  irq_req
);

    logic [PORT_W-1:0] data_w  [NUM_PORTS];
    logic [1:0]        mode_w  [NUM_PORTS];
    logic [PORT_W-1:0] ie_w    [NUM_PORTS];
    logic [PORT_W-1:0] level_w [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = wr_en && (wr_addr[ADDR_W-1:2] == PSEL_W'(p));

        gpio_port_regs #(.PORT_W(PORT_W)) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .wr_kind (wr_addr[1:0]),
            .wr_data (wr_data),
            .data_o  (data_w[p]),
            .mode_o  (mode_w[p]),
            .ie_o    (ie_w[p])
        );

        gpio_pad_decode #(.PORT_W(PORT_W)) dec_i (
            .mode_i  (mode_w[p]),
            .data_i  (data_w[p]),
            .pu_o    (pu_en[p*PORT_W +: PORT_W]),
            .sink_o  (sink_en[p*PORT_W +: PORT_W]),
            .drive_o (drive_en[p*PORT_W +: PORT_W])
        );

        gpio_input_sync #(.PORT_W(PORT_W)) sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_i   (pad_in[p*PORT_W +: PORT_W]),
            .ie_i    (ie_w[p]),
            .level_o (level_w[p]),
            .irq_o   (irq_req[p*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_addr[ADDR_W-1:2] == PSEL_W'(p)) begin
                case (rd_addr[1:0])
                    RK_DATA:  rd_data = level_w[p];
                    RK_MODE:  rd_data = PORT_W'(mode_w[p]);
                    RK_IRQEN: rd_data = ie_w[p];
                    default:  rd_data = '0;
                endcase
            end
        end
    end

    // R6
    drive_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu_en & drive_en) == '0));

    // R4
    sink_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pu_en | drive_en) & sink_en) == '0));

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [23:0] pad_in = '1;
    logic [23:0] pu_en, sink_en, drive_en, irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pu_en(pu_en), .sink_en(sink_en),
        .drive_en(drive_en), .irq_req(irq_req)
    );

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        tick();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    // driver: present a read address, push the expected value
    task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
        tick();
        rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare queued reads in the middle of the cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(t, {16'h0, rd_data}, {16'h0, e});
        end
    end

    task automatic pads(logic [23:0] pu, logic [23:0] sk, logic [23:0] dr, string tag);
        check({tag, " pu"}, pu_en, pu);
        check({tag, " sink"}, sink_en, sk);
        check({tag, " drive"}, drive_en, dr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        pads(24'hFFFFFF, 24'h0, 24'h0, "R1");
        check("R1 irq", irq_req, 24'h0);
        rd(4'h6, 8'h00, "R1 ie p1");
        rd(4'h9, 8'h00, "R1 mode p2");

        // R2 R3 R4 resistive data
        wr(4'h0, 8'hA5);
        pads(24'hFFFFA5, 24'h00005A, 24'h0, "R3 R4 resistive");

        // R5 push-pull on port 1, R7 port 0 untouched
        wr(4'h5, 8'h01);
        wr(4'h4, 8'h3C);
        pads(24'hFF00A5, 24'h00C35A, 24'h003C00, "R5 R7 pushpull");

        // R6 open-drain then reserved on port 2
        wr(4'h9, 8'h02);
        wr(4'h8, 8'hF0);
        pads(24'h0000A5, 24'h0FC35A, 24'h003C00, "R6 open-drain");
        wr(4'h9, 8'h03);
        pads(24'h0000A5, 24'h0FC35A, 24'h003C00, "R6 reserved");
        rd(4'h9, 8'h03, "R9 mode p2");
        rd(4'h5, 8'h01, "R9 mode p1");

        // R11 ignored writes
        wr(4'h3, 8'h00);
        wr(4'hC, 8'h00);
        wr(4'hE, 8'hFF);
        pads(24'h0000A5, 24'h0FC35A, 24'h003C00, "R11 ignored");
        rd(4'h2, 8'h00, "R11 ie p0");
        rd(4'hC, 8'h00, "R9 absent port");
        rd(4'h3, 8'h00, "R9 kind 11");

        // R8 read returns synchronized pad, not latch
        tick();
        pad_in[7:0] = 8'h0F;
        rd(4'h0, 8'hFF, "R8 one edge");
        rd(4'h0, 8'h0F, "R8 two edges");

        // R10 interrupts: enable bit 0 only
        wr(4'h2, 8'h01);
        rd(4'h2, 8'h01, "R9 ie p0");
        pad_in[7:0] = 8'h0C;
        repeat (4) begin
            tick();
            check("R10 falling", irq_req, 24'h0);
        end
        pad_in[7:0] = 8'h0F;
        tick();
        check("R10 edge1", irq_req, 24'h0);
        tick();
        check("R10 pulse", irq_req, 24'h000001);
        tick();
        check("R10 single", irq_req, 24'h0);
        tick();
        check("R10 idle", irq_req, 24'h0);

        tick();
        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule